// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the digital front end of a high-resolution voltage DAC. A host drives it over a 3-wire serial link: an active-low frame select, a serial clock and a data line. Each frame is a 24-bit command. The block decodes the command into a write or a read of one of its internal registers, which are the converter code, a control word, a clearcode word and a software control action. The result of a read is shifted back to the host on a serial data output during the frame that follows the read.

The held converter code drives the converter core as a segmented switch pattern. The six most significant code bits are decoded into 63 equally weighted thermometer lines. The twelve remaining bits drive a binary ladder directly.

All serial inputs are resynchronised to the system clock `clk` by a parameterised synchroniser chain, and their edges are detected in that domain. Each half period of the serial clock must therefore last at least SYNC_STAGES+2 system clocks. With the default of two stages, a 35 MHz serial clock needs a system clock of about 280 MHz or faster.

Top module: `dac_serial_port`

## Requirements
- R1: A frame runs from the fall to the rise of `frame_n`. Data is sampled on each rising `sclk` edge, most significant bit first. A frame is executed only if exactly 24 rising edges occur while `frame_n` is low. A frame with fewer or more edges changes no register and no pending readback.
- R2: Bit 23 is the read flag and bits 22..20 are the address. A write (flag 0) to address 1 loads the converter code, to address 2 loads the control word (bits 19..0), and to address 3 loads the clearcode word (bits 19..0).
- R3: The converter code is taken from data bits 19..2. Data bits 1..0 of a code write are ignored.
- R4: Segment line `seg_en[i]` is high exactly when code bits 17..12, read as an unsigned number, exceed i. The lines therefore form a contiguous run of ones from bit 0.
- R5: `ladder_sw[11:0]` equals code bits 11..0.
- R6: A read (flag 1) of address 1, 2 or 3 makes the next executed frame shift out a 24-bit word on `sdo`, MSB first. The word is {1, address, contents}. For the code register the contents are the code followed by two zero bits. The first bit is valid after `frame_n` falls, and each following bit appears after a falling `sclk` edge. A frame that follows any other executed frame shifts out zeros. `sdo` is low while `frame_n` is high.
- R7: Address 0 is a no-operation whatever the flag. Writes to addresses 5..7, and reads of addresses 4..7, are also no-operations. None of these changes any register, and the frame that follows shifts out zeros.
- R8: A write to address 4 is a software control action on data bits. If bit 2 is set, the code, control and clearcode registers all clear to zero. Otherwise, if bit 1 is set, the code is loaded from clearcode bits 19..2.
- R9: While `rst_n` is low, every register is zero, all segment and ladder lines are low and `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial readback data out |
| seg_en | output | 63 | Thermometer segment enables |
| ladder_sw | output | 12 | Binary ladder switch drives |

## Verification
The decoder is exercised with four codes: full scale, a code whose top field is 1, a mid-scale code with the top field at 32, and clearcode-derived values. Together they show whether the thermometer count, its contiguity and the ladder bits are taken from the right code bits. Reads are issued singly, back to back, and across a truncated frame. These cases distinguish a readback that is tied to the next executed frame from one that is tied to the next physical frame or that overwrites itself. Frames of 23 and 25 bits, no-operations with either flag, reserved addresses and both software control actions show that only legal, exact-length frames act on state.

// File: rtl/dacsif_pkg.sv
package dacsif_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_NOP  = 3'd0,
      A_CODE = 3'd1,
      A_CTRL = 3'd2,
      A_CLR  = 3'd3,
      A_SOFT = 3'd4
   } reg_addr_e;

   // bit positions inside the software control action word
   localparam int SOFT_LOAD_BIT = 1;
   localparam int SOFT_RST_BIT  = 2;
endpackage

// File: rtl/dacsif_sync.sv
module dacsif_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dacsif_rx.sv
module dacsif_rx #(
   parameter int FRAME_W = 24,
   localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_s,
   input  logic               sclk_s,
   input  logic               sdi_s,
   input  logic [FRAME_W-1:0] load_word,
   output logic [FRAME_W-1:0] word,
   output logic               done,
   output logic               sdo
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   logic               sclk_q, frame_q;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] rx, tx;
   logic               sck_rise, sck_fall, frm_fall, frm_rise;

   assign sck_rise = sclk_s & ~sclk_q;
   assign sck_fall = ~sclk_s & sclk_q;
   assign frm_fall = frame_q & ~frame_s;
   assign frm_rise = ~frame_q & frame_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         frame_q <= 1'b1;
         cnt     <= '0;
         rx      <= '0;
         tx      <= '0;
         done    <= 1'b0;
      end else begin
         sclk_q  <= sclk_s;
         frame_q <= frame_s;
         done    <= 1'b0;
         if (frm_fall) begin
            cnt <= '0;
            tx  <= load_word;
         end else if (frm_rise) begin
            tx   <= '0;
            done <= (cnt == CNT_FULL);
         end else if (!frame_s) begin
            if (sck_rise) begin
               rx <= {rx[FRAME_W-2:0], sdi_s};
               if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
            if (sck_fall) tx <= {tx[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign word = rx;
   assign sdo  = tx[FRAME_W-1];
endmodule

// File: rtl/dacsif_regs.sv
module dacsif_regs
   import dacsif_pkg::*;
#(
   parameter int DATA_W  = 20,
   parameter int CODE_W  = 18,
   localparam int FRAME_W = 1 + ADDR_W + DATA_W,
   localparam int PAD_W   = DATA_W - CODE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec,
   input  logic [FRAME_W-1:0] word,
   output logic [CODE_W-1:0]  code,
   output logic [FRAME_W-1:0] rd_word
);
   logic              rd;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic [CODE_W-1:0] code_r;
   logic [DATA_W-1:0] ctrl_r, clr_r;
   logic [FRAME_W-1:0] rb_r;

   assign rd   = word[FRAME_W-1];
   assign addr = word[FRAME_W-2 -: ADDR_W];
   assign data = word[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_r <= '0;
         ctrl_r <= '0;
         clr_r  <= '0;
         rb_r   <= '0;
      end else if (exec) begin
         rb_r <= '0;
         if (!rd) begin
            case (addr)
               A_CODE: code_r <= data[DATA_W-1 -: CODE_W];
               A_CTRL: ctrl_r <= data;
               A_CLR:  clr_r  <= data;
               A_SOFT: begin
                  if (data[SOFT_RST_BIT]) begin
                     code_r <= '0;
                     ctrl_r <= '0;
                     clr_r  <= '0;
                  end else if (data[SOFT_LOAD_BIT]) begin
                     code_r <= clr_r[DATA_W-1 -: CODE_W];
                  end
               end
               default: ;
            endcase
         end else begin
            case (addr)
               A_CODE:  rb_r <= {1'b1, addr, code_r, {PAD_W{1'b0}}};
               A_CTRL:  rb_r <= {1'b1, addr, ctrl_r};
               A_CLR:   rb_r <= {1'b1, addr, clr_r};
               default: ;
            endcase
         end
      end
   end

   assign code    = code_r;
   assign rd_word = rb_r;
endmodule

// File: rtl/dacsif_seg.sv
module dacsif_seg #(
   parameter int CODE_W   = 18,
   parameter int SEG_BITS = 6,
   localparam int SEG_N    = (2 ** SEG_BITS) - 1,
   localparam int LADDER_W = CODE_W - SEG_BITS
) (
   input  logic [CODE_W-1:0]   code,
   output logic [SEG_N-1:0]    therm,
   output logic [LADDER_W-1:0] ladder
);
   logic [SEG_BITS-1:0] top;
   assign top = code[CODE_W-1 -: SEG_BITS];

   generate
      for (genvar i = 0; i < SEG_N; i++) begin : g_seg
         assign therm[i] = (top > SEG_BITS'(i));
      end
   endgenerate

   assign ladder = code[LADDER_W-1:0];
endmodule

// File: rtl/dac_serial_port.sv
module dac_serial_port
   import dacsif_pkg::*;
#(
   parameter int DATA_W      = 20,
   parameter int CODE_W      = 18,
   parameter int SEG_BITS    = 6,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W  = 1 + ADDR_W + DATA_W,
   localparam int SEG_N    = (2 ** SEG_BITS) - 1,
   localparam int LADDER_W = CODE_W - SEG_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_n,
   input  logic                sclk,
   input  logic                sdi,
   output logic                sdo,
   output logic [SEG_N-1:0]    seg_en,
   output logic [LADDER_W-1:0] ladder_sw
);
   generate
      if (CODE_W >= DATA_W || SEG_BITS >= CODE_W || SEG_BITS < 1 || SYNC_STAGES < 0) begin : g_bad_cfg
         $error("dac_serial_port: illegal width or stage configuration");
      end
   endgenerate

   logic               frame_s, sclk_s, sdi_s;
   logic               done;
   logic [FRAME_W-1:0] word, rd_word;
   logic [CODE_W-1:0]  code;

   dacsif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_frame (
      .clk(clk), .rst_n(rst_n), .d(frame_n), .q(frame_s));
   dacsif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   dacsif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

   dacsif_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .frame_s(frame_s), .sclk_s(sclk_s),
      .sdi_s(sdi_s), .load_word(rd_word), .word(word), .done(done), .sdo(sdo));

   dacsif_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .exec(done), .word(word),
      .code(code), .rd_word(rd_word));

   dacsif_seg #(.CODE_W(CODE_W), .SEG_BITS(SEG_BITS)) u_seg (
      .code(code), .therm(seg_en), .ladder(ladder_sw));
endmodule

// File: rtl/dacsif_chk.sv
module dacsif_chk #(
   parameter int CODE_W   = 18,
   parameter int SEG_BITS = 6,
   parameter int SEG_N    = 63,
   parameter int LADDER_W = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_s,
   input logic                done,
   input logic                sdo,
   input logic [CODE_W-1:0]   code,
   input logic [SEG_N-1:0]    seg_en,
   input logic [LADDER_W-1:0] ladder_sw
);
   // R4: lines form a run of ones starting at bit 0
   p_therm_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((seg_en & (seg_en + SEG_N'(1))) == '0));

   // R4: number of lit lines matches the top code field
   p_therm_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(seg_en) == int'(code[CODE_W-1 -: SEG_BITS])));

   // R1: the code only moves in the cycle after an executed frame
   p_code_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(code));

   // R6: output idles low between frames
   p_sdo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_s && $past(frame_s)) |-> !sdo);

   // R9: everything at zero while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_zero_r9: assert (seg_en == '0 && ladder_sw == '0 && !sdo);
      end
   end
endmodule

bind dac_serial_port dacsif_chk #(
   .CODE_W(CODE_W), .SEG_BITS(SEG_BITS), .SEG_N(SEG_N), .LADDER_W(LADDER_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_s(frame_s), .done(done), .sdo(sdo),
   .code(code), .seg_en(seg_en), .ladder_sw(ladder_sw));

// File: tb/test_dac_serial_port.sv
module test_dac_serial_port;
   localparam int HP = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        sdo;
   logic [62:0] seg_en;
   logic [11:0] ladder_sw;

   int errors = 0;
   int checks = 0;
   bit done_flag = 0;

   // model state
   logic [17:0] m_code = '0;
   logic [19:0] m_ctrl = '0, m_clr = '0;
   logic [23:0] m_rb = '0;

   logic [23:0] exp_q[$];
   int          mon_n = 0;
   logic [23:0] mon_word = '0;

   always #10 clk = ~clk;

   dac_serial_port i_dac_serial_port (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .seg_en(seg_en), .ladder_sw(ladder_sw));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // monitor: collect sdo bits at each rising sclk inside a frame
   always @(negedge frame_n) begin
      mon_n = 0;
      mon_word = '0;
   end
   always @(posedge sclk) begin
      if (!frame_n) begin
         if (mon_n < 24) mon_word = {mon_word[22:0], sdo};
         mon_n++;
      end
   end
   always @(posedge frame_n) begin
      if (mon_n == 24 && exp_q.size() > 0) begin
         logic [23:0] e;
         e = exp_q.pop_front();
         chk("R6 readback word", {40'b0, mon_word}, {40'b0, e});
      end
   end

   function automatic logic [23:0] mk(input bit rd, input logic [2:0] a, input logic [19:0] d);
      return {rd, a, d};
   endfunction

   task automatic shift_frame(input logic [23:0] w, input int nbits);
      frame_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int b = 0; b < nbits; b++) begin
         sdi = (b < 24) ? w[23-b] : 1'b0;
         repeat (HP) @(negedge clk);
         sclk = 1'b1;
         repeat (HP) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HP) @(negedge clk);
      frame_n = 1'b1;
      repeat (3*HP) @(negedge clk);
   endtask

   // driver: valid frame, model update and expected readback push
   task automatic do_frame(input logic [23:0] w);
      logic [23:0] nrb;
      exp_q.push_back(m_rb);
      nrb = '0;
      if (!w[23]) begin
         case (w[22:20])
            3'd1: m_code = w[19:2];
            3'd2: m_ctrl = w[19:0];
            3'd3: m_clr  = w[19:0];
            3'd4: begin
               if (w[2]) begin m_code = '0; m_ctrl = '0; m_clr = '0; end
               else if (w[1]) m_code = m_clr[19:2];
            end
            default: ;
         endcase
      end else begin
         case (w[22:20])
            3'd1: nrb = {1'b1, 3'd1, m_code, 2'b00};
            3'd2: nrb = {1'b1, 3'd2, m_ctrl};
            3'd3: nrb = {1'b1, 3'd3, m_clr};
            default: ;
         endcase
      end
      m_rb = nrb;
      shift_frame(w, 24);
   endtask

   task automatic chk_out(input string req);
      logic [62:0] e;
      for (int i = 0; i < 63; i++) e[i] = (int'(m_code[17:12]) > i);
      chk({req, " segments"}, {1'b0, seg_en}, {1'b0, e});
      chk({req, " ladder"}, {52'b0, ladder_sw}, {52'b0, m_code[11:0]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9 reset state
      chk("R9 seg", {1'b0, seg_en}, 64'd0);
      chk("R9 ladder", {52'b0, ladder_sw}, 64'd0);
      chk("R9 sdo", {63'b0, sdo}, 64'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 R4 R5 full scale
      do_frame(mk(0, 3'd1, {18'h3FFFF, 2'b00}));
      chk_out("R4 R5 full scale");
      // R3 low bits ignored, R4 single segment
      do_frame(mk(0, 3'd1, {18'h01ABC, 2'b11}));
      chk_out("R3 R4 one segment");
      // R6 read code then NOP returns it
      do_frame(mk(1, 3'd1, 20'h0));
      do_frame(mk(0, 3'd0, 20'h0));
      // R4 mid scale
      do_frame(mk(0, 3'd1, {18'h20123, 2'b01}));
      chk_out("R4 mid scale");
      // R2 control and clearcode, back-to-back reads R6
      do_frame(mk(0, 3'd2, 20'hA5A5A));
      do_frame(mk(0, 3'd3, 20'h5C3F1));
      do_frame(mk(1, 3'd2, 20'h0));
      do_frame(mk(1, 3'd3, 20'h0));
      do_frame(mk(0, 3'd0, 20'h0));
      do_frame(mk(0, 3'd0, 20'h0));
      chk_out("R2 code kept");

      // R1 short and long frames discarded
      shift_frame(mk(0, 3'd1, 20'h00000), 23);
      chk_out("R1 short frame");
      shift_frame(mk(0, 3'd1, 20'h00000), 25);
      chk_out("R1 long frame");
      // R1 pending readback survives a discarded frame
      do_frame(mk(1, 3'd2, 20'h0));
      shift_frame(mk(0, 3'd2, 20'h11111), 23);
      do_frame(mk(0, 3'd0, 20'h0));

      // R7 no-ops and reserved addresses
      do_frame(mk(1, 3'd0, 20'hFFFFF));
      chk_out("R7 nop with flag");
      do_frame(mk(0, 3'd5, 20'hFFFFF));
      chk_out("R7 reserved write");
      do_frame(mk(1, 3'd4, 20'h0));
      do_frame(mk(0, 3'd0, 20'h0));
      do_frame(mk(1, 3'd2, 20'h0));
      do_frame(mk(0, 3'd0, 20'h0));

      // R8 load clearcode into code, then clear everything
      do_frame(mk(0, 3'd4, 20'h00002));
      chk_out("R8 load clearcode");
      do_frame(mk(0, 3'd1, {18'h3F001, 2'b00}));
      do_frame(mk(0, 3'd4, 20'h00006));
      chk_out("R8 soft clear");
      do_frame(mk(1, 3'd3, 20'h0));
      do_frame(mk(1, 3'd2, 20'h0));
      do_frame(mk(0, 3'd0, 20'h0));
      chk("R6 queue drained", {32'b0, 32'(exp_q.size())}, 64'd0);

      finish_run();
   end
endmodule